// File: doc/BRIEF.md
# Step Configuration Sequencer

This block holds the per-step routing words for compound vector operations and replays them to a switch fabric one scheduling step at a time. A host core fills a small on-block store through a plain write port of address, data and enable while the block is idle. A start pulse then names a first entry and a number of steps. The block presents one routing word per step and raises a one-cycle completion pulse after the final step.

How long each step stays on the outputs depends on the functional units it feeds. If units are constrained and the vector-length-to-lane ratio reaches the longest chain of dependent operations on one unit, a step can only be issued once every chain-length cycles. Otherwise a step can issue every cycle. A per-step hold value from the host stretches a step so that it lasts as long as its slowest unit. The block takes the larger of the two figures. All pacing inputs are captured when a start is accepted.

Top module: `step_cfg_sequencer`

## Requirements
- R1: After reset the block is idle: `busy`, `cfg_valid` and `done` are low, and `cfg_step`, `cfg_sel` and `cfg_sec` are zero.
- R2: A write while idle stores `wr_data` at `wr_addr`. When such an entry is played, its bits [5i+4:5i] appear on `cfg_sel` at the same positions for i = 0..11. Bits [61:60] appear on `cfg_sec`. Bits [63:62] are not output.
- R3: A start is accepted only when the block is not busy and 1 <= `start_count` <= 32. Counts of 0 or above 32 are ignored, and `busy` stays low. From the cycle after acceptance, `busy` and `cfg_valid` are high until the last step ends.
- R4: The issue interval is `pace_lpl` cycles when `pace_constrained` is 1, `pace_lpl` is nonzero and `pace_vl_ratio` >= `pace_lpl`. In every other case it is 1 cycle.
- R5: Each step lasts max(interval, hold) cycles, where hold is `step_hold` and a hold of 0 counts as 1. The routing word is stable for the whole step. Pacing inputs are captured at the accepted start.
- R6: Step k of a run shows the entry at address (base + k) mod 32, and `cfg_step` equals k. Steps run 0..count-1 with no gaps.
- R7: `done` is high for exactly one cycle, the cycle after the final cycle of the last step. In that cycle `busy` and `cfg_valid` are low. The block then accepts a new start.
- R8: Writes presented while `busy` is high are dropped, and the stored entry keeps its old value.
- R9: A start presented while `busy` is high has no effect on the run in progress.
- R10: When a write and an accepted start happen in the same idle cycle and the write address equals the base, the first step shows the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write enable |
| wr_addr | input | 5 | Host write address |
| wr_data | input | 64 | Host write word |
| start | input | 1 | Playback request |
| start_base | input | 5 | First entry of the run |
| start_count | input | 6 | Number of steps (1..32) |
| pace_constrained | input | 1 | Unit reuse constraint present |
| pace_vl_ratio | input | 8 | Vector length divided by lane count |
| pace_lpl | input | 8 | Longest dependent chain on one unit |
| step_hold | input | 8 | Per-step latency-matching hold in cycles |
| cfg_valid | output | 1 | Routing word valid |
| cfg_sel | output | 60 | Twelve 5-bit primary switch selects |
| cfg_sec | output | 2 | Secondary switch select |
| cfg_step | output | 5 | Index of the current step in the run |
| busy | output | 1 | Playback in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A host write and a playback start can fall in the same cycle. This is provoked in two ways. The first is an idle cycle in which both target the same entry. That case is judged by requiring the first step to carry the new word. The second is a mid-run cycle in which a stray start and a write to a not-yet-played entry are driven together. That case is judged by requiring the remaining steps, their indices and their durations to match a model that never saw either request.

// File: rtl/seq_pkg.sv
// Shared constants and state type for the step configuration sequencer.
// Assumes the store depth is a power of two so that addresses wrap naturally.
package seq_pkg;
    localparam int SEQ_DEPTH   = 32;
    localparam int SEQ_WORD_W  = 64;
    localparam int SEQ_SEL_W   = 5;
    localparam int SEQ_NUM_SEL = 12;
    localparam int SEQ_SEC_W   = 2;
    localparam int SEQ_PACE_W  = 8;

    typedef enum logic [1:0] {
        RUN_IDLE = 2'd0,
        RUN_PLAY = 2'd1,
        RUN_DONE = 2'd2
    } run_state_t;
endpackage

// File: rtl/seq_cfg_store.sv
// Routing-word store: a flop array with one write port and one combinational
// read port. A write to the address being read in the same cycle is
// forwarded to the read data. Write gating against playback is done by the caller.
module seq_cfg_store #(
    parameter int DEPTH  = seq_pkg::SEQ_DEPTH,
    parameter int WORD_W = seq_pkg::SEQ_WORD_W,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    // Clear the store on reset and commit host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Read the entry, forwarding a same-cycle write to the same address.
    always_comb begin
        if (wr_en && (wr_addr == rd_addr)) rd_data = wr_data;
        else                               rd_data = mem_q[rd_addr];
    end
endmodule

// File: rtl/seq_pace.sv
// Step pacing: computes the step duration from the unit constraint, the
// vector-length ratio, the dependent-chain length and the hold value, then
// counts each step down. Settings are captured on load. step_last is high in
// the final cycle of the current step.
module seq_pace #(
    parameter int PACE_W = seq_pkg::SEQ_PACE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic              constrained,
    input  logic [PACE_W-1:0] vl_ratio,
    input  logic [PACE_W-1:0] lpl,
    input  logic [PACE_W-1:0] hold,
    output logic              step_last
);
    logic [PACE_W-1:0] interval_c;
    logic [PACE_W-1:0] hold_c;
    logic [PACE_W-1:0] period_c;
    logic [PACE_W-1:0] period_q;
    logic [PACE_W-1:0] cnt_q;

    // Derive the issue interval and the stretched step length.
    always_comb begin
        if (constrained && (lpl != '0) && (vl_ratio >= lpl)) interval_c = lpl;
        else                                                  interval_c = PACE_W'(1);
        hold_c   = (hold == '0) ? PACE_W'(1) : hold;
        period_c = (hold_c > interval_c) ? hold_c : interval_c;
    end

    // Capture the step length at start and count down each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= PACE_W'(1);
            cnt_q    <= '0;
        end else if (load) begin
            period_q <= period_c;
            cnt_q    <= period_c - PACE_W'(1);
        end else if (advance) begin
            cnt_q    <= period_q - PACE_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q    <= cnt_q - PACE_W'(1);
        end
    end

    assign step_last = (cnt_q == '0);
endmodule

// File: rtl/seq_step_ctrl.sv
// Playback control: accepts a start when not playing and the count is in
// range, walks the addresses with wrap-around, and emits a one-cycle done state.
// Assumes DEPTH is a power of two.
module seq_step_ctrl #(
    parameter int DEPTH = seq_pkg::SEQ_DEPTH,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  count,
    input  logic              step_last,
    output logic              accept,
    output logic              advance,
    output logic              capture,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] step_idx,
    output logic              busy,
    output logic              done,
    output logic              wr_allow
);
    import seq_pkg::*;

    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DEPTH);

    run_state_t        state_q;
    logic [ADDR_W-1:0] next_addr_q;
    logic [CNT_W-1:0]  remain_q;
    logic [ADDR_W-1:0] step_q;
    logic              count_ok;
    logic              finish;

    // Decide acceptance, step advance and run end for this cycle.
    always_comb begin
        count_ok = (count != '0) && (count <= MAX_CNT);
        accept   = start && (state_q != RUN_PLAY) && count_ok;
        advance  = (state_q == RUN_PLAY) && step_last && (remain_q != '0);
        finish   = (state_q == RUN_PLAY) && step_last && (remain_q == '0);
        capture  = accept || advance;
        rd_addr  = accept ? base : next_addr_q;
        wr_allow = (state_q != RUN_PLAY);
    end

    // Advance the playback state, the address pointer and the step counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= RUN_IDLE;
            next_addr_q <= '0;
            remain_q    <= '0;
            step_q      <= '0;
        end else if (accept) begin
            state_q     <= RUN_PLAY;
            next_addr_q <= base + ADDR_W'(1);
            remain_q    <= count - CNT_W'(1);
            step_q      <= '0;
        end else if (advance) begin
            next_addr_q <= next_addr_q + ADDR_W'(1);
            remain_q    <= remain_q - CNT_W'(1);
            step_q      <= step_q + ADDR_W'(1);
        end else if (finish) begin
            state_q     <= RUN_DONE;
        end else if (state_q == RUN_DONE) begin
            state_q     <= RUN_IDLE;
        end
    end

    assign step_idx = step_q;
    assign busy     = (state_q == RUN_PLAY);
    assign done     = (state_q == RUN_DONE);
endmodule

// File: rtl/step_cfg_sequencer.sv
// Top of the step configuration sequencer. It ties the store, the pacing
// counter and the playback control together and registers the routing word
// for each step. The word is split into primary selects and the secondary
// select. The two top bits of each stored word are not used.
module step_cfg_sequencer #(
    parameter int DEPTH   = seq_pkg::SEQ_DEPTH,
    parameter int WORD_W  = seq_pkg::SEQ_WORD_W,
    parameter int SEL_W   = seq_pkg::SEQ_SEL_W,
    parameter int NUM_SEL = seq_pkg::SEQ_NUM_SEL,
    parameter int SEC_W   = seq_pkg::SEQ_SEC_W,
    parameter int PACE_W  = seq_pkg::SEQ_PACE_W,
    localparam int ADDR_W    = $clog2(DEPTH),
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int SEL_BUS_W = SEL_W * NUM_SEL
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    start_base,
    input  logic [CNT_W-1:0]     start_count,
    input  logic                 pace_constrained,
    input  logic [PACE_W-1:0]    pace_vl_ratio,
    input  logic [PACE_W-1:0]    pace_lpl,
    input  logic [PACE_W-1:0]    step_hold,
    output logic                 cfg_valid,
    output logic [SEL_BUS_W-1:0] cfg_sel,
    output logic [SEC_W-1:0]     cfg_sec,
    output logic [ADDR_W-1:0]    cfg_step,
    output logic                 busy,
    output logic                 done
);
    logic              accept;
    logic              advance;
    logic              capture;
    logic              step_last;
    logic              wr_allow;
    logic              wr_gated;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_data;
    logic [WORD_W-1:0] word_q;

    assign wr_gated = wr_en && wr_allow;

    seq_cfg_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_gated),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    seq_pace #(.PACE_W(PACE_W)) u_pace (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .advance     (advance),
        .constrained (pace_constrained),
        .vl_ratio    (pace_vl_ratio),
        .lpl         (pace_lpl),
        .hold        (step_hold),
        .step_last   (step_last)
    );

    seq_step_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .base      (start_base),
        .count     (start_count),
        .step_last (step_last),
        .accept    (accept),
        .advance   (advance),
        .capture   (capture),
        .rd_addr   (rd_addr),
        .step_idx  (cfg_step),
        .busy      (busy),
        .done      (done),
        .wr_allow  (wr_allow)
    );

    // Register the routing word at the first cycle of each step.
    always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (capture) word_q <= rd_data;
    end

    // Split the registered word into the per-port select fields.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        assign cfg_sel[g*SEL_W +: SEL_W] = word_q[g*SEL_W +: SEL_W];
    end
    assign cfg_sec   = word_q[SEL_BUS_W +: SEC_W];
    assign cfg_valid = busy;
endmodule

// File: rtl/step_cfg_sequencer_chk.sv
// Property checker for the step configuration sequencer, bound to the top.
// It observes ports only.
module step_cfg_sequencer_chk #(
    parameter int ADDR_W    = 5,
    parameter int SEL_BUS_W = 60,
    parameter int SEC_W     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic                 cfg_valid,
    input logic [ADDR_W-1:0]    cfg_step,
    input logic [SEL_BUS_W-1:0] cfg_sel,
    input logic [SEC_W-1:0]     cfg_sec
);
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !cfg_valid));

    assert_end_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_busy_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_step_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (cfg_step != $past(cfg_step)))
            |-> (cfg_step == $past(cfg_step) + ADDR_W'(1)));

    assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (cfg_step == $past(cfg_step)))
            |-> $stable({cfg_sec, cfg_sel}));
endmodule

bind step_cfg_sequencer step_cfg_sequencer_chk #(
    .ADDR_W    (ADDR_W),
    .SEL_BUS_W (SEL_BUS_W),
    .SEC_W     (SEC_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .cfg_valid (cfg_valid),
    .cfg_step  (cfg_step),
    .cfg_sel   (cfg_sel),
    .cfg_sec   (cfg_sec)
);

// File: tb/test_step_cfg_sequencer.sv
// Directed bench: one task per scenario, each checking its own results.
module test_step_cfg_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        start = 1'b0;
    logic [4:0]  start_base = '0;
    logic [5:0]  start_count = '0;
    logic        pace_constrained = 1'b0;
    logic [7:0]  pace_vl_ratio = '0;
    logic [7:0]  pace_lpl = '0;
    logic [7:0]  step_hold = '0;
    logic        cfg_valid;
    logic [59:0] cfg_sel;
    logic [1:0]  cfg_sec;
    logic [4:0]  cfg_step;
    logic        busy;
    logic        done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [63:0] model [32];

    always #5 clk = ~clk;

    step_cfg_sequencer i_step_cfg_sequencer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start(start), .start_base(start_base), .start_count(start_count),
        .pace_constrained(pace_constrained), .pace_vl_ratio(pace_vl_ratio),
        .pace_lpl(pace_lpl), .step_hold(step_hold), .cfg_valid(cfg_valid),
        .cfg_sel(cfg_sel), .cfg_sec(cfg_sec), .cfg_step(cfg_step), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input int i);
        return 64'hC3A5_0F1E_2D3C_4B5A ^ (64'(i) * 64'h0001_0003_0005_0007) ^ (64'(i) << 58);
    endfunction

    task automatic host_write(input int a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model[a] = d;
    endtask

    // Play a run and check every cycle of it, optionally injecting a stray
    // start and a write at sample index inj.
    task automatic run_play(input int base, input int count, input bit con, input int ratio,
                            input int lpl, input int hold, input int period, input int inj,
                            input string tag);
        @(negedge clk);
        start = 1'b1; start_base = 5'(base); start_count = 6'(count);
        pace_constrained = con; pace_vl_ratio = 8'(ratio); pace_lpl = 8'(lpl); step_hold = 8'(hold);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < count * period; i++) begin
            int s;
            int a;
            s = i / period;
            a = (base + s) % 32;
            chk(busy && cfg_valid && !done, {tag, " busy/valid"}, {61'd0, busy, cfg_valid, done}, 64'd6);
            chk({cfg_sec, cfg_sel} == model[a][61:0], {tag, " word"}, {2'b0, cfg_sec, cfg_sel}, {2'b0, model[a][61:0]});
            chk(cfg_step == 5'(s), {tag, " step"}, 64'(cfg_step), 64'(s));
            if (i == inj) begin
                start = 1'b1; start_base = 5'((base + 7) % 32); start_count = 6'd5;
                pace_constrained = 1'b0; step_hold = 8'd1;
                wr_en = 1'b1; wr_addr = 5'((base + count - 1) % 32); wr_data = 64'hDEAD_BEEF_DEAD_BEEF;
            end else begin
                start = 1'b0; wr_en = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0; wr_en = 1'b0;
        chk(done && !busy && !cfg_valid, {tag, " R7 done pulse"}, {61'd0, busy, cfg_valid, done}, 64'd1);
        @(negedge clk);
        chk(!done && !busy, {tag, " R7 done ends"}, {62'd0, busy, done}, 64'd0);
    endtask

    task automatic t_reset;
        chk(!busy && !cfg_valid && !done, "R1 idle flags", {61'd0, busy, cfg_valid, done}, 64'd0);
        chk(cfg_step == '0 && cfg_sel == '0 && cfg_sec == '0, "R1 outputs zero",
            {cfg_sec, cfg_sel}, 64'd0);
    endtask

    task automatic t_load;
        for (int i = 0; i < 32; i++) host_write(i, pat(i));
    endtask

    task automatic t_basic;      run_play(2, 4, 1'b0, 0, 0, 0, 1, -1, "R2 R6 basic"); endtask
    task automatic t_interval;   run_play(5, 3, 1'b1, 8, 3, 0, 3, -1, "R4 lpl interval"); endtask
    task automatic t_ratio_low;  run_play(9, 3, 1'b1, 2, 3, 1, 1, -1, "R4 ratio below lpl"); endtask
    task automatic t_uncon;      run_play(12, 2, 1'b0, 9, 4, 0, 1, -1, "R4 unconstrained"); endtask
    task automatic t_hold;       run_play(14, 3, 1'b0, 0, 0, 4, 4, -1, "R5 hold stretch"); endtask
    task automatic t_lpl_wins;   run_play(1, 2, 1'b1, 5, 5, 2, 5, -1, "R5 interval wins"); endtask
    task automatic t_hold_wins;  run_play(20, 2, 1'b1, 5, 5, 7, 7, -1, "R5 hold wins"); endtask
    task automatic t_wrap;       run_play(30, 5, 1'b0, 0, 0, 1, 1, -1, "R6 wrap"); endtask
    task automatic t_full;       run_play(0, 32, 1'b0, 0, 0, 2, 2, -1, "R6 full depth"); endtask

    task automatic t_busy_inject;
        run_play(4, 6, 1'b0, 0, 0, 2, 2, 1, "R8 R9 busy inject");
        run_play(9, 1, 1'b0, 0, 0, 1, 1, -1, "R8 entry kept");
    endtask

    task automatic t_bad_count(input int cnt);
        @(negedge clk);
        start = 1'b1; start_base = 5'd3; start_count = 6'(cnt);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(!busy && !cfg_valid && !done, "R3 bad count ignored", {61'd0, busy, cfg_valid, done}, 64'd0);
            @(negedge clk);
        end
    endtask

    task automatic t_same_cycle;
        logic [63:0] d;
        d = 64'h3FED_CBA9_8765_4321;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd11; wr_data = d;
        start = 1'b1; start_base = 5'd11; start_count = 6'd2;
        pace_constrained = 1'b0; step_hold = 8'd1;
        @(negedge clk);
        wr_en = 1'b0; start = 1'b0;
        model[11] = d;
        chk({cfg_sec, cfg_sel} == d[61:0], "R10 bypass word", {2'b0, cfg_sec, cfg_sel}, {2'b0, d[61:0]});
        @(negedge clk);
        chk({cfg_sec, cfg_sel} == model[12][61:0], "R10 next word", {2'b0, cfg_sec, cfg_sel}, {2'b0, model[12][61:0]});
        @(negedge clk);
        chk(done && !busy, "R10 R7 done", {62'd0, busy, done}, 64'd1);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_load;
        t_basic;
        t_interval;
        t_ratio_low;
        t_uncon;
        t_hold;
        t_lpl_wins;
        t_hold_wins;
        t_wrap;
        t_full;
        t_busy_inject;
        t_bad_count(0);
        t_bad_count(33);
        t_same_cycle;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule